// File: doc/BRIEF.md
# Dual-Bank Memory Select Controller

This block is a clocked front end for a combined byte-wide SRAM and flash memory that share one address bus, one data bus and one set of control strobes. It takes active-low enables for each bank, together with output-enable and write-enable. Each cycle it decides which bank owns the bus. It performs byte reads and writes on an internal SRAM array. For flash cycles it produces a select and a read strobe toward an external flash port. It also reports when the data bus should be driven and when the block is idle.

Every strobe, the address and the write data pass through a two-stage synchronizer, and the outputs are registered once after that. A write is committed when either the write-enable or the SRAM enable rises, whichever comes first. The address and data used are the values held while both strobes were low. A parameter selects a reduced-pin variant. In that variant the output-enable pin also serves as the SRAM enable, and the separate SRAM enable input is ignored. The SRAM depth is a parameter and sits at the bottom of the address space. Flash erase and program sequencing are not part of this block.

Top module: `dual_bank_sel`

## Requirements
- R1: With the SRAM enable low and the flash enable high, `bank_o` reads 1 (SRAM), `flash_cs_n_o` stays high and `standby_o` is low.
- R2: With the flash enable low, `bank_o` reads 2 (flash) and `flash_cs_n_o` is low. `flash_rd_n_o` is low exactly when output-enable is low and write-enable is high.
- R3: When both bank enables are low, the flash bank owns the cycle and the SRAM enable has no effect: no SRAM data is driven and no SRAM write commits. `collide_o` pulses high for exactly one cycle at the onset of such an overlap. This applies only to the split-pin variant.
- R4: When both bank enables are high, `bank_o` reads 0, `standby_o` is high, `drive_o` is low and `flash_cs_n_o` is high.
- R5: `drive_o` is high only for an SRAM cycle with output-enable low and write-enable high. In that case `rdata_o` carries the byte stored at the current address.
- R6: Whenever output-enable is high, `drive_o` is low.
- R7: An SRAM write stores the held data at the held address when write-enable or the SRAM enable rises after a period with both low. A later rise of the other strobe writes nothing.
- R8: The level of output-enable during an SRAM write has no effect on the stored byte.
- R9: A write to an address at or above `SRAM_DEPTH` is dropped and does not alias into the array. A read from such an address returns 0xFF.
- R10: With `SHARED_PIN` set, `oe_n_i` acts as the SRAM enable when the flash enable is high and as output-enable for flash cycles. `sram_en_n_i` is ignored and `collide_o` stays low.
- R11: A change on the inputs reaches the outputs after exactly three rising clock edges. After two edges the outputs still show the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Shared byte address |
| wdata_i | input | 8 | Write data from the shared bus |
| sram_en_n_i | input | 1 | SRAM bank enable, active low (ignored when SHARED_PIN is set) |
| flash_en_n_i | input | 1 | Flash bank enable, active low |
| oe_n_i | input | 1 | Output-enable, active low; also the SRAM enable when SHARED_PIN is set |
| we_n_i | input | 1 | Write-enable, active low |
| rdata_o | output | 8 | SRAM read data, zero when not driving |
| drive_o | output | 1 | Data bus driver enable for SRAM reads |
| flash_cs_n_o | output | 1 | Flash bank select, active low |
| flash_rd_n_o | output | 1 | Flash read strobe, active low |
| bank_o | output | 2 | Owning bank: 0 none, 1 SRAM, 2 flash |
| collide_o | output | 1 | One-cycle pulse when both enables start overlapping |
| standby_o | output | 1 | Neither bank selected |

## Verification
The assertions assume that the strobes, once synchronized, describe the same cycle as the address and data, so that address and write data do not change in the cycles around a committing strobe edge. The stimulus changes inputs only on falling clock edges. It holds address and data steady from before the strobes fall until several cycles after they rise again, and it waits five cycles after each change before sampling. During the exhaustive sweeps of the control combinations, the address and write data are set to a byte that is already stored there. Any write that the sweep's transitions cause therefore leaves the array unchanged.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BANK_NONE  = 2'd0,
        BANK_SRAM  = 2'd1,
        BANK_FLASH = 2'd2
    } bank_e;
endpackage

// File: rtl/dbs_sync.sv
`timescale 1ns/1ps
module dbs_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dbs_arbiter.sv
`timescale 1ns/1ps
module dbs_arbiter
    import dbs_pkg::*;
#(
    parameter bit SHARED_PIN = 1'b0
) (
    input  logic  sel_n_i,
    input  logic  fen_n_i,
    input  logic  oe_n_i,
    input  logic  we_n_i,
    input  logic  p_sel_n_i,
    input  logic  p_fen_n_i,
    input  logic  p_we_n_i,
    output bank_e bank_o,
    output logic  standby_o,
    output logic  collide_o,
    output logic  sram_rd_o,
    output logic  commit_o,
    output logic  flash_cs_n_o,
    output logic  flash_rd_n_o
);
    logic flash_own, sram_own, both_now, both_prev, wr_held;

    // flash dominates any overlap of the two enables
    assign flash_own = !fen_n_i;
    assign sram_own  = fen_n_i && !sel_n_i;

    always_comb begin
        if (flash_own)     bank_o = BANK_FLASH;
        else if (sram_own) bank_o = BANK_SRAM;
        else               bank_o = BANK_NONE;
    end

    assign standby_o = fen_n_i && sel_n_i;

    // overlap only exists when the two enables are separate pins
    assign both_now  = !SHARED_PIN && !fen_n_i && !sel_n_i;
    assign both_prev = !SHARED_PIN && !p_fen_n_i && !p_sel_n_i;
    assign collide_o = both_now && !both_prev;

    assign sram_rd_o    = sram_own && !oe_n_i && we_n_i;
    assign flash_cs_n_o = fen_n_i;
    assign flash_rd_n_o = !(flash_own && !oe_n_i && we_n_i);

    // write held in previous sample; first rising strobe ends it
    assign wr_held  = p_fen_n_i && !p_sel_n_i && !p_we_n_i;
    assign commit_o = wr_held && (sel_n_i || we_n_i);
endmodule

// File: rtl/dbs_sram.sv
`timescale 1ns/1ps
module dbs_sram
    import dbs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic w_ok, r_ok;

    assign w_ok = waddr_i < LIMIT;
    assign r_ok = raddr_i < LIMIT;

    always_ff @(posedge clk) begin
        if (wr_i && w_ok) mem[waddr_i[IW-1:0]] <= wdata_i;
    end

    assign rdata_o = r_ok ? mem[raddr_i[IW-1:0]] : {BYTE_W{1'b1}};
endmodule

// File: rtl/dual_bank_sel.sv
`timescale 1ns/1ps
module dual_bank_sel
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SRAM_DEPTH = 16,
    parameter bit SHARED_PIN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              sram_en_n_i,
    input  logic              flash_en_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    output logic [7:0]        rdata_o,
    output logic              drive_o,
    output logic              flash_cs_n_o,
    output logic              flash_rd_n_o,
    output logic [1:0]        bank_o,
    output logic              collide_o,
    output logic              standby_o
);
    localparam int SYNC_W = ADDR_W + BYTE_W + 4;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{(ADDR_W + BYTE_W){1'b0}}, 4'hF};

    typedef struct packed {
        bank_e             bank;
        logic              standby;
        logic              collide;
        logic              drive;
        logic [BYTE_W-1:0] rdata;
        logic              cs_n;
        logic              rd_n;
        logic [ADDR_W-1:0] p_addr;
        logic [BYTE_W-1:0] p_wdata;
        logic              p_sel_n;
        logic              p_fen_n;
        logic              p_we_n;
    } state_t;

    state_t st_d, st_q;

    logic [SYNC_W-1:0] s_vec;
    logic [ADDR_W-1:0] s_addr;
    logic [BYTE_W-1:0] s_wdata;
    logic s_sen, s_fen, s_oe, s_we, sel_n, eff_oe;

    dbs_sync #(.W(SYNC_W), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({addr_i, wdata_i, sram_en_n_i, flash_en_n_i, oe_n_i, we_n_i}),
        .q_o   (s_vec)
    );

    assign {s_addr, s_wdata, s_sen, s_fen, s_oe, s_we} = s_vec;

    generate
        if (SHARED_PIN) begin : g_shared
            assign sel_n  = s_oe;
            assign eff_oe = s_oe;
        end else begin : g_split
            assign sel_n  = s_sen;
            assign eff_oe = s_oe;
        end
    endgenerate

    bank_e arb_bank;
    logic arb_stby, arb_coll, arb_rd, arb_commit, arb_cs_n, arb_rd_n;
    logic [BYTE_W-1:0] mem_rdata;

    dbs_arbiter #(.SHARED_PIN(SHARED_PIN)) u_arb (
        .sel_n_i      (sel_n),
        .fen_n_i      (s_fen),
        .oe_n_i       (eff_oe),
        .we_n_i       (s_we),
        .p_sel_n_i    (st_q.p_sel_n),
        .p_fen_n_i    (st_q.p_fen_n),
        .p_we_n_i     (st_q.p_we_n),
        .bank_o       (arb_bank),
        .standby_o    (arb_stby),
        .collide_o    (arb_coll),
        .sram_rd_o    (arb_rd),
        .commit_o     (arb_commit),
        .flash_cs_n_o (arb_cs_n),
        .flash_rd_n_o (arb_rd_n)
    );

    dbs_sram #(.DEPTH(SRAM_DEPTH), .ADDR_W(ADDR_W)) u_sram (
        .clk     (clk),
        .wr_i    (arb_commit),
        .waddr_i (st_q.p_addr),
        .wdata_i (st_q.p_wdata),
        .raddr_i (s_addr),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        st_d         = st_q;
        st_d.bank    = arb_bank;
        st_d.standby = arb_stby;
        st_d.collide = arb_coll;
        st_d.drive   = arb_rd;
        st_d.rdata   = arb_rd ? mem_rdata : '0;
        st_d.cs_n    = arb_cs_n;
        st_d.rd_n    = arb_rd_n;
        st_d.p_addr  = s_addr;
        st_d.p_wdata = s_wdata;
        st_d.p_sel_n = sel_n;
        st_d.p_fen_n = s_fen;
        st_d.p_we_n  = s_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.bank    <= BANK_NONE;
            st_q.standby <= 1'b1;
            st_q.cs_n    <= 1'b1;
            st_q.rd_n    <= 1'b1;
            st_q.p_sel_n <= 1'b1;
            st_q.p_fen_n <= 1'b1;
            st_q.p_we_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o      = st_q.rdata;
    assign drive_o      = st_q.drive;
    assign flash_cs_n_o = st_q.cs_n;
    assign flash_rd_n_o = st_q.rd_n;
    assign bank_o       = st_q.bank;
    assign collide_o    = st_q.collide;
    assign standby_o    = st_q.standby;

    // R3
    collide_is_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide_o |-> (bank_o == BANK_FLASH) && !drive_o);

    // R3
    collide_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide_o |=> !collide_o);

    // R4
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !drive_o && flash_cs_n_o && flash_rd_n_o && (bank_o == BANK_NONE));

    // R5
    drive_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> (bank_o == BANK_SRAM) && flash_cs_n_o);

    // R2
    flash_read_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rd_n_o |-> !flash_cs_n_o && !drive_o);
endmodule

// File: tb/dual_bank_sel_bench.sv
`timescale 1ns/1ps
module dual_bank_sel_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // split-pin instance
    logic [18:0] a_addr = '0;
    logic [7:0]  a_wdata = '0;
    logic a_sen = 1'b1, a_fen = 1'b1, a_oe = 1'b1, a_we = 1'b1;
    logic [7:0] a_rdata;
    logic a_drive, a_cs_n, a_rd_n, a_coll, a_stby;
    logic [1:0] a_bank;

    // shared-pin instance
    logic [18:0] b_addr = '0;
    logic [7:0]  b_wdata = '0;
    logic b_sen = 1'b1, b_fen = 1'b1, b_pin = 1'b1, b_we = 1'b1;
    logic [7:0] b_rdata;
    logic b_drive, b_cs_n, b_rd_n, b_coll, b_stby;
    logic [1:0] b_bank;

    dual_bank_sel #(.ADDR_W(19), .SRAM_DEPTH(16), .SHARED_PIN(1'b0)) u_dual_bank_sel (
        .clk(clk), .rst_n(rst_n), .addr_i(a_addr), .wdata_i(a_wdata),
        .sram_en_n_i(a_sen), .flash_en_n_i(a_fen), .oe_n_i(a_oe), .we_n_i(a_we),
        .rdata_o(a_rdata), .drive_o(a_drive), .flash_cs_n_o(a_cs_n),
        .flash_rd_n_o(a_rd_n), .bank_o(a_bank), .collide_o(a_coll), .standby_o(a_stby)
    );

    dual_bank_sel #(.ADDR_W(19), .SRAM_DEPTH(16), .SHARED_PIN(1'b1)) u_dual_bank_sel_sh (
        .clk(clk), .rst_n(rst_n), .addr_i(b_addr), .wdata_i(b_wdata),
        .sram_en_n_i(b_sen), .flash_en_n_i(b_fen), .oe_n_i(b_pin), .we_n_i(b_we),
        .rdata_o(b_rdata), .drive_o(b_drive), .flash_cs_n_o(b_cs_n),
        .flash_rd_n_o(b_rd_n), .bank_o(b_bank), .collide_o(b_coll), .standby_o(b_stby)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_a(input logic [18:0] ad, input logic [7:0] dt,
                        input logic oe, input logic by_sen);
        @(negedge clk);
        a_addr = ad; a_wdata = dt; a_fen = 1'b1; a_oe = oe; a_sen = 1'b1; a_we = 1'b1;
        settle(3);
        a_sen = 1'b0; a_we = 1'b0;
        settle(4);
        if (by_sen) a_sen = 1'b1; else a_we = 1'b1;
        settle(4);
        a_sen = 1'b1; a_we = 1'b1; a_oe = 1'b1;
        settle(4);
    endtask

    task automatic rd_a(input logic [18:0] ad, output logic [7:0] dt, output logic dv);
        @(negedge clk);
        a_addr = ad; a_fen = 1'b1; a_sen = 1'b0; a_oe = 1'b0; a_we = 1'b1;
        settle(5);
        dt = a_rdata; dv = a_drive;
        a_sen = 1'b1; a_oe = 1'b1;
        settle(4);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic dv;
        int cnt;

        settle(4);
        rst_n = 1'b1;
        settle(2);

        // reset state: standby, nothing selected (R4)
        chk("R4 reset bank", a_bank, 0);
        chk("R4 reset standby", a_stby, 1);
        chk("R4 reset drive", a_drive, 0);
        chk("R4 reset cs_n", a_cs_n, 1);
        chk("R4 reset rd_n", a_rd_n, 1);
        chk("R3 reset collide", a_coll, 0);

        // fill the array, alternating closing strobe (R7) and OE level (R8)
        for (int a = 0; a < 16; a++) wr_a(19'(a), pat(a), a[1], a[0]);
        for (int a = 0; a < 16; a++) begin
            rd_a(19'(a), d, dv);
            chk(a[0] ? "R7 commit on enable rise" : "R7 commit on write rise", d, pat(a));
            chk(a[1] ? "R8 write with oe high" : "R8 write with oe low", d, pat(a));
            chk("R5 drive on read", dv, 1);
        end

        // out-of-range accesses (R9)
        for (int k = 0; k < 4; k++) begin
            wr_a(19'(16 + k), ~pat(k), 1'b1, k[0]);
            rd_a(19'(16 + k), d, dv);
            chk("R9 oob read value", d, 8'hFF);
            rd_a(19'(k), d, dv);
            chk("R9 oob write no alias", d, pat(k));
        end
        wr_a(19'h7FFFF, 8'h00, 1'b1, 1'b0);
        rd_a(19'h7FFFF, d, dv);
        chk("R9 top address read", d, 8'hFF);

        // exhaustive control sweep, split pins
        @(negedge clk);
        a_addr = 19'd3; a_wdata = pat(3);
        for (int c = 0; c < 16; c++) begin
            int eb, es, ec, er, ed;
            a_sen = c[3]; a_fen = c[2]; a_oe = c[1]; a_we = c[0];
            settle(5);
            eb = !c[2] ? 2 : (!c[3] ? 1 : 0);
            es = (c[2] && c[3]) ? 1 : 0;
            ec = c[2];
            er = (!c[2] && !c[1] && c[0]) ? 0 : 1;
            ed = (eb == 1 && !c[1] && c[0]) ? 1 : 0;
            chk(eb == 2 ? (c[3] ? "R2 bank" : "R3 bank") : (eb == 1 ? "R1 bank" : "R4 bank"), a_bank, eb);
            chk(es ? "R4 standby" : "R1 standby", a_stby, es);
            chk("R2 flash select", a_cs_n, ec);
            chk("R2 flash read strobe", a_rd_n, er);
            chk(c[1] ? "R6 no drive with oe high" : "R5 drive", a_drive, ed);
            if (ed == 1) chk("R5 read data", a_rdata, pat(3));
        end
        @(negedge clk);
        a_sen = 1'b1; a_fen = 1'b1; a_oe = 1'b1; a_we = 1'b1;
        settle(5);

        // collision pulse and SRAM ignored during overlap (R3)
        for (int r = 0; r < 2; r++) begin
            @(negedge clk);
            a_addr = 19'd3; a_sen = 1'b0; a_fen = 1'b1; a_oe = 1'b0; a_we = 1'b1;
            settle(5);
            a_fen = 1'b0;
            cnt = 0;
            for (int t = 0; t < 10; t++) begin
                @(negedge clk);
                cnt += int'(a_coll);
            end
            chk("R3 single collide pulse", cnt, 1);
            chk("R3 flash owns overlap", a_bank, 2);
            chk("R3 sram not driven", a_drive, 0);
            a_fen = 1'b1;
            settle(5);
        end
        @(negedge clk);
        a_wdata = 8'hEE; a_oe = 1'b1; a_sen = 1'b0; a_fen = 1'b0; a_we = 1'b1;
        settle(4);
        a_we = 1'b0;
        settle(4);
        a_we = 1'b1;
        settle(4);
        a_sen = 1'b1; a_fen = 1'b1;
        settle(4);
        rd_a(19'd3, d, dv);
        chk("R3 no sram write in overlap", d, pat(3));

        // latency: outputs move on the third rising edge (R11)
        @(negedge clk);
        a_addr = 19'd5; a_sen = 1'b0; a_fen = 1'b1; a_oe = 1'b0; a_we = 1'b1;
        settle(2);
        chk("R11 old state after two edges", a_bank, 0);
        settle(1);
        chk("R11 new state after three edges", a_bank, 1);
        chk("R11 data after three edges", a_rdata, pat(5));
        a_sen = 1'b1; a_oe = 1'b1;
        settle(5);

        // shared-pin variant: write with separate enable held high (R10)
        @(negedge clk);
        b_addr = 19'd2; b_wdata = 8'h5A; b_sen = 1'b1; b_fen = 1'b1; b_pin = 1'b1; b_we = 1'b1;
        settle(3);
        b_pin = 1'b0; b_we = 1'b0;
        settle(4);
        b_pin = 1'b1;
        settle(4);
        b_we = 1'b1;
        settle(4);
        b_pin = 1'b0;
        settle(5);
        chk("R10 shared read drive", b_drive, 1);
        chk("R10 shared read data", b_rdata, 8'h5A);
        b_pin = 1'b1;
        settle(5);

        for (int c = 0; c < 16; c++) begin
            int eb, es, er, ed;
            b_sen = c[3]; b_fen = c[2]; b_pin = c[1]; b_we = c[0];
            settle(5);
            eb = !c[2] ? 2 : (!c[1] ? 1 : 0);
            es = (c[2] && c[1]) ? 1 : 0;
            er = (!c[2] && !c[1] && c[0]) ? 0 : 1;
            ed = (c[2] && !c[1] && c[0]) ? 1 : 0;
            chk("R10 shared bank", b_bank, eb);
            chk("R10 shared standby", b_stby, es);
            chk("R10 shared flash select", b_cs_n, c[2]);
            chk("R10 shared flash read", b_rd_n, er);
            chk("R10 shared drive", b_drive, ed);
            chk("R10 shared no collide", b_coll, 0);
            if (ed == 1) chk("R10 shared data", b_rdata, 8'h5A);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule